// File: doc/BRIEF.md
# Masked Vector Component Write Filter

This block sits on the write side of a data unpacker. For each unpacked 32-bit element it decides what value, if any, lands in one lane (X, Y, Z or W) of the destination vector. A 2-bit selector picks the source for each lane and each write cycle from a 32-bit mask word. The source is the element after an addition-mode transform, a per-lane row register, or a per-cycle column register. A selector value can also cancel the write.

There are four row registers, indexed by lane, and four column registers, indexed by write cycle. A register-write port loads either bank. In accumulate mode the row registers also act as running sums: the element is added into the lane's row register and the new sum is emitted. The result word and its write strobe come out registered, one clock after the element is presented.

Top module: `fwf_write_filter`

## Requirements
- R1: After reset `out_data` is 0, `out_strobe` is 0, and all row and column registers read back as 0.
- R2: `out_strobe` rises in the cycle after an element is presented with `in_valid` high, in step with `out_data`. A cycle without `in_valid` gives no strobe, and `out_data` keeps its value.
- R3: With `mask_en` low the selector is taken as 0, whatever `mask_word` holds.
- R4: With `mask_en` high, the selector is `mask_word[8*b + 2*in_comp +: 2]`. Here b is `in_cycle` when `in_cycle` is below 3, and 3 otherwise. Lane encoding is X=0, Y=1, Z=2, W=3.
- R5: Selector 1 outputs the row register of lane `in_comp`.
- R6: Selector 2 outputs column register b, where b is `in_cycle` clamped to 3.
- R7: Selector 3 suppresses the write: `out_strobe` stays low and `out_data` keeps its previous value.
- R8: With selector 0 and `add_mode`=1, the output is `in_data` plus the lane's row register. The row register is unchanged.
- R9: With selector 0 and `add_mode`=2, the lane's row register becomes row + `in_data` modulo 2^32, and that new value is output.
- R10: With selector 0 and `add_mode` 0 or 3, `in_data` is output unchanged.
- R11: When `cmd_byte & 8'h6F` equals `8'h6F`, selector 0 outputs `in_data` unchanged for every mode, and no row register accumulates.
- R12: `reg_we` writes `reg_wdata` to entry `reg_idx` of the row bank (`reg_bank`=0) or the column bank (`reg_bank`=1). An element presented in the same cycle still sees the old value; the new value is visible from the next cycle on.
- R13: If a register-port write and an accumulation target the same row register in the same cycle, the register-port value is kept. The output of that cycle is still the accumulated sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Element present this cycle |
| in_data | input | DW | Unpacked element |
| in_comp | input | 2 | Destination lane, X=0 .. W=3 |
| in_cycle | input | CYC_W | Write-cycle counter |
| mask_word | input | 32 | Four bytes of four 2-bit selectors |
| mask_en | input | 1 | Masking enabled for this command |
| add_mode | input | 2 | 0 plain, 1 offset, 2 accumulate, 3 plain |
| cmd_byte | input | 8 | Low byte of the command code |
| reg_we | input | 1 | Register-port write enable |
| reg_bank | input | 1 | 0 row bank, 1 column bank |
| reg_idx | input | 2 | Register index |
| reg_wdata | input | DW | Register write data |
| out_data | output | DW | Value for the destination lane |
| out_strobe | output | 1 | Destination write enable |

## Verification
The bench builds the block with DW=32 and CYC_W=3. A 3-bit cycle counter lets the stimulus drive cycle values 4 to 7, so the clamp onto the last mask byte and the last column register is exercised beyond the plain 0 to 3 range. Because DW is the full 32 bits, accumulation past 2^32 can be driven. This checks the wrap of a row register seeded near its maximum.

// File: rtl/fwf_pkg.sv
package fwf_pkg;

    typedef enum logic [1:0] {
        SEL_XFORM = 2'd0,
        SEL_ROW   = 2'd1,
        SEL_COL   = 2'd2,
        SEL_SKIP  = 2'd3
    } sel_e;

    typedef enum logic [1:0] {
        MODE_PLAIN  = 2'd0,
        MODE_OFFSET = 2'd1,
        MODE_ACCUM  = 2'd2,
        MODE_RSVD   = 2'd3
    } mode_e;

    localparam int unsigned NLANE     = 4;
    localparam int unsigned LANE_W    = 2;
    localparam int unsigned MASK_W    = 32;
    localparam logic [7:0]  PASS_BITS = 8'h6F;

endpackage

// File: rtl/fwf_sel_decode.sv
module fwf_sel_decode
    import fwf_pkg::*;
#(
    parameter int unsigned CYC_W = 3
) (
    input  logic [MASK_W-1:0] mask_word,
    input  logic              mask_en,
    input  logic [LANE_W-1:0] comp,
    input  logic [CYC_W-1:0]  cycle,
    output sel_e              sel,
    output logic [1:0]        byte_idx
);
    localparam logic [CYC_W-1:0] LAST_CYC = CYC_W'(3);

    logic [4:0] bit_base;
    logic [1:0] field;

    always_comb begin
        if (cycle >= LAST_CYC) begin
            byte_idx = 2'd3;
        end else begin
            byte_idx = cycle[1:0];
        end
        bit_base = {byte_idx, comp, 1'b0};
        field    = mask_word[bit_base +: 2];
        sel      = mask_en ? sel_e'(field) : SEL_XFORM;
    end

endmodule

// File: rtl/fwf_reg_bank.sv
module fwf_reg_bank #(
    parameter int unsigned DW   = 32,
    parameter int unsigned NENT = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [$clog2(NENT)-1:0] wr_idx,
    input  logic [DW-1:0]           wr_data,
    input  logic                    acc_en,
    input  logic [$clog2(NENT)-1:0] acc_idx,
    input  logic [DW-1:0]           acc_val,
    input  logic [$clog2(NENT)-1:0] rd_idx,
    output logic [DW-1:0]           rd_data
);
    localparam int unsigned IDX_W = $clog2(NENT);

    logic [DW-1:0] ent_q [NENT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NENT; i++) begin
                ent_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NENT; i++) begin
                if (wr_en && wr_idx == IDX_W'(i)) begin
                    ent_q[i] <= wr_data;
                end else if (acc_en && acc_idx == IDX_W'(i)) begin
                    ent_q[i] <= ent_q[i] + acc_val;
                end
            end
        end
    end

    assign rd_data = ent_q[rd_idx];

    generate
        for (genvar g = 0; g < NENT; g++) begin : g_chk
            assert_wr_wins_R13: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_idx == IDX_W'(g)) |=> (ent_q[g] == $past(wr_data)));

            assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
                (!(wr_en && wr_idx == IDX_W'(g)) && !(acc_en && acc_idx == IDX_W'(g)))
                |=> $stable(ent_q[g]));
        end
    endgenerate

endmodule

// File: rtl/fwf_write_filter.sv
module fwf_write_filter
    import fwf_pkg::*;
#(
    parameter int unsigned DW    = 32,
    parameter int unsigned CYC_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DW-1:0]     in_data,
    input  logic [1:0]        in_comp,
    input  logic [CYC_W-1:0]  in_cycle,
    input  logic [31:0]       mask_word,
    input  logic              mask_en,
    input  logic [1:0]        add_mode,
    input  logic [7:0]        cmd_byte,
    input  logic              reg_we,
    input  logic              reg_bank,
    input  logic [1:0]        reg_idx,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     out_data,
    output logic              out_strobe
);
    sel_e          sel;
    logic [1:0]    col_idx;
    logic [DW-1:0] row_rd;
    logic [DW-1:0] col_rd;
    logic [DW-1:0] xform;
    logic [DW-1:0] result;
    logic          passthru;
    logic          acc_go;
    logic          wr_fire;

    fwf_sel_decode #(.CYC_W(CYC_W)) u_dec (
        .mask_word (mask_word),
        .mask_en   (mask_en),
        .comp      (in_comp),
        .cycle     (in_cycle),
        .sel       (sel),
        .byte_idx  (col_idx)
    );

    fwf_reg_bank #(.DW(DW), .NENT(NLANE)) u_rows (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_we && !reg_bank),
        .wr_idx  (reg_idx),
        .wr_data (reg_wdata),
        .acc_en  (acc_go),
        .acc_idx (in_comp),
        .acc_val (in_data),
        .rd_idx  (in_comp),
        .rd_data (row_rd)
    );

    fwf_reg_bank #(.DW(DW), .NENT(NLANE)) u_cols (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_we && reg_bank),
        .wr_idx  (reg_idx),
        .wr_data (reg_wdata),
        .acc_en  (1'b0),
        .acc_idx (2'd0),
        .acc_val ({DW{1'b0}}),
        .rd_idx  (col_idx),
        .rd_data (col_rd)
    );

    assign passthru = ((cmd_byte & PASS_BITS) == PASS_BITS);

    // Mode transform for selector 0
    always_comb begin
        xform  = in_data;
        acc_go = 1'b0;
        if (!passthru) begin
            case (mode_e'(add_mode))
                MODE_OFFSET: xform = in_data + row_rd;
                MODE_ACCUM: begin
                    xform  = in_data + row_rd;
                    acc_go = in_valid && (sel == SEL_XFORM);
                end
                default: xform = in_data;
            endcase
        end
    end

    // Source select
    always_comb begin
        unique case (sel)
            SEL_XFORM: result = xform;
            SEL_ROW:   result = row_rd;
            SEL_COL:   result = col_rd;
            SEL_SKIP:  result = out_data;
        endcase
    end

    assign wr_fire = in_valid && (sel != SEL_SKIP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_strobe <= 1'b0;
            out_data   <= '0;
        end else begin
            out_strobe <= wr_fire;
            if (wr_fire) begin
                out_data <= result;
            end
        end
    end

    assert_no_strobe_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_strobe && $stable(out_data)));

    assert_unmasked_writes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mask_en) |=> out_strobe);

    assert_skip_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sel == SEL_SKIP) |=> (!out_strobe && $stable(out_data)));

    assert_pass_raw_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && passthru && sel == SEL_XFORM) |=> (out_data == $past(in_data)));

endmodule

// File: tb/fwf_write_filter_tb_top.sv
`timescale 1ns/1ps
module fwf_write_filter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic [1:0]  in_comp = '0;
    logic [2:0]  in_cycle = '0;
    logic [31:0] mask_word = '0;
    logic        mask_en = 1'b0;
    logic [1:0]  add_mode = '0;
    logic [7:0]  cmd_byte = '0;
    logic        reg_we = 1'b0;
    logic        reg_bank = 1'b0;
    logic [1:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] out_data;
    logic        out_strobe;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    logic [31:0] m_row [4];
    logic [31:0] m_col [4];
    logic [31:0] m_last;

    logic        exp_s_q [$];
    logic [31:0] exp_d_q [$];
    string       exp_r_q [$];

    localparam logic [31:0] M_ROW  = 32'h5555_5555;
    localparam logic [31:0] M_COL  = 32'hAAAA_AAAA;
    localparam logic [31:0] M_SKIP = 32'hFFFF_FFFF;

    always #4 clk = ~clk;

    fwf_write_filter #(.DW(32), .CYC_W(3)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_comp(in_comp), .in_cycle(in_cycle), .mask_word(mask_word),
        .mask_en(mask_en), .add_mode(add_mode), .cmd_byte(cmd_byte),
        .reg_we(reg_we), .reg_bank(reg_bank), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .out_data(out_data), .out_strobe(out_strobe)
    );

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Driver: applies one cycle of stimulus and pushes the expected result
    task automatic drive(input logic v, input logic [31:0] d, input int comp,
                         input int cyc, input logic [31:0] m, input logic me,
                         input int md, input logic [7:0] cb, input logic we,
                         input logic bk, input int ix, input logic [31:0] wd,
                         input string tag);
        int          by;
        int          s;
        logic        st;
        logic        acc;
        logic [31:0] val;
        @(negedge clk);
        in_valid = v; in_data = d; in_comp = comp[1:0]; in_cycle = cyc[2:0];
        mask_word = m; mask_en = me; add_mode = md[1:0]; cmd_byte = cb;
        reg_we = we; reg_bank = bk; reg_idx = ix[1:0]; reg_wdata = wd;
        by  = (cyc >= 3) ? 3 : cyc;
        s   = me ? int'((m >> (by * 8 + comp * 2)) & 32'd3) : 0;
        st  = 1'b0;
        acc = 1'b0;
        val = m_last;
        if (v) begin
            case (s)
                0: begin
                    st = 1'b1;
                    if ((cb & 8'h6F) == 8'h6F) val = d;
                    else if (md == 1) val = d + m_row[comp];
                    else if (md == 2) begin val = d + m_row[comp]; acc = 1'b1; end
                    else val = d;
                end
                1: begin st = 1'b1; val = m_row[comp]; end
                2: begin st = 1'b1; val = m_col[by]; end
                default: st = 1'b0;
            endcase
        end
        if (acc) m_row[comp] = val;
        if (we) begin
            if (bk) m_col[ix] = wd;
            else m_row[ix] = wd;
        end
        if (st) m_last = val;
        exp_s_q.push_back(st);
        exp_d_q.push_back(m_last);
        exp_r_q.push_back(tag);
    endtask

    task automatic elem(input logic [31:0] d, input int comp, input int cyc,
                        input logic [31:0] m, input logic me, input int md,
                        input logic [7:0] cb, input string tag);
        drive(1'b1, d, comp, cyc, m, me, md, cb, 1'b0, 1'b0, 0, 32'h0, tag);
    endtask

    task automatic regw(input logic bk, input int ix, input logic [31:0] wd, input string tag);
        drive(1'b0, 32'h0, 0, 0, 32'h0, 1'b0, 0, 8'h00, 1'b1, bk, ix, wd, tag);
    endtask

    task automatic idle(input string tag);
        drive(1'b0, 32'h0, 0, 0, 32'h0, 1'b0, 0, 8'h00, 1'b0, 1'b0, 0, 32'h0, tag);
    endtask

    // Monitor: compares each registered result with the scoreboard head
    logic        mon_s;
    logic [31:0] mon_d;
    string       mon_r;
    always @(posedge clk) begin
        #1;
        if (exp_s_q.size() != 0) begin
            mon_s = exp_s_q.pop_front();
            mon_d = exp_d_q.pop_front();
            mon_r = exp_r_q.pop_front();
            checks++;
            if (out_strobe !== mon_s || out_data !== mon_d) begin
                fails++;
                $display("FAIL %s: strobe=%0b data=%h expected strobe=%0b data=%h",
                         mon_r, out_strobe, out_data, mon_s, mon_d);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R2 watchdog: run did not end, cycles=200000 expected fewer");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 4; i++) begin m_row[i] = '0; m_col[i] = '0; end
        m_last = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (out_strobe !== 1'b0 || out_data !== 32'h0) begin
            fails++;
            $display("FAIL R1 reset: strobe=%0b data=%h expected strobe=0 data=0",
                     out_strobe, out_data);
        end
        rst_n = 1'b1;

        // R1: banks clear after reset
        for (int c = 0; c < 4; c++) elem(32'hDEAD_0000, c, 0, M_ROW, 1'b1, 0, 8'h00, "R1 row clear");
        for (int c = 0; c < 4; c++) elem(32'hDEAD_0001, 0, c, M_COL, 1'b1, 0, 8'h00, "R1 col clear");

        // R12: load both banks
        for (int i = 0; i < 4; i++) regw(1'b0, i, 32'h0000_1000 * (i + 1), "R12 row load");
        for (int i = 0; i < 4; i++) regw(1'b1, i, 32'hC0C0_0000 + i, "R12 col load");
        for (int c = 0; c < 4; c++) elem(32'h0, c, 1, M_ROW, 1'b1, 0, 8'h00, "R5 row read");
        // R6: column by cycle, clamp above 2
        for (int c = 0; c < 8; c++) elem(32'h0, c % 4, c, M_COL, 1'b1, 0, 8'h00, "R6 col read");

        // R10: plain modes
        elem(32'h1234_5678, 0, 0, 32'h0, 1'b0, 0, 8'h00, "R10 mode0");
        elem(32'h8765_4321, 3, 2, 32'h0, 1'b0, 3, 8'h00, "R10 mode3");
        // R3: mask disabled ignores a skip-everything mask
        elem(32'h0000_0007, 1, 0, M_SKIP, 1'b0, 1, 8'h00, "R3 mask off");
        // R8: offset mode, row unchanged
        elem(32'h0000_0005, 2, 0, 32'h0, 1'b0, 1, 8'h00, "R8 offset");
        elem(32'h0, 2, 0, M_ROW, 1'b1, 0, 8'h00, "R8 row kept");

        // R9: accumulate with wrap
        regw(1'b0, 1, 32'hFFFF_FFF0, "R9 seed");
        elem(32'h0000_0020, 1, 0, 32'h0, 1'b0, 2, 8'h00, "R9 wrap");
        elem(32'h0000_0003, 1, 0, 32'h0, 1'b0, 2, 8'h00, "R9 accumulate");
        elem(32'h0, 1, 0, M_ROW, 1'b1, 0, 8'h00, "R9 row read");

        // R11: pass-through command codes
        elem(32'h0000_ABCD, 3, 0, 32'h0, 1'b0, 2, 8'h6F, "R11 pass accum");
        elem(32'h0, 3, 0, M_ROW, 1'b1, 0, 8'h00, "R11 row untouched");
        elem(32'h0000_0011, 0, 0, 32'h0, 1'b0, 1, 8'hFF, "R11 pass offset");
        elem(32'h0000_0011, 0, 0, 32'h0, 1'b0, 1, 8'h6E, "R11 no pass");

        // R4: selector field positions across lanes and cycles
        for (int c = 0; c < 8; c++)
            for (int l = 0; l < 4; l++) begin
                elem(32'hD000 + l * 16 + c, l, c, 32'h1BE4_4EB1, 1'b1, 0, 8'h00, "R4 field A");
                elem(32'hE000 + l * 16 + c, l, c, 32'h27D8_9C63, 1'b1, 1, 8'h00, "R4 field B");
            end

        // R7: suppressed write holds output
        elem(32'h0000_0055, 2, 1, M_SKIP, 1'b1, 0, 8'h00, "R7 skip");
        elem(32'h0000_0066, 0, 6, M_SKIP, 1'b1, 2, 8'h00, "R7 skip accum");
        elem(32'h0, 0, 0, M_ROW, 1'b1, 0, 8'h00, "R7 row untouched");

        // R13: same-cycle write and accumulate
        drive(1'b1, 32'h1, 0, 0, 32'h0, 1'b0, 2, 8'h00, 1'b1, 1'b0, 0, 32'h7777, "R13 collide");
        elem(32'h0, 0, 0, M_ROW, 1'b1, 0, 8'h00, "R13 port wins");
        drive(1'b1, 32'h2, 2, 0, 32'h0, 1'b0, 2, 8'h00, 1'b1, 1'b0, 3, 32'h3333, "R13 disjoint");
        elem(32'h0, 2, 0, M_ROW, 1'b1, 0, 8'h00, "R13 acc row");
        elem(32'h0, 3, 0, M_ROW, 1'b1, 0, 8'h00, "R13 wr row");

        // R12: same-cycle read sees old value
        drive(1'b1, 32'h0, 2, 0, M_ROW, 1'b1, 0, 8'h00, 1'b1, 1'b0, 2, 32'h2222, "R12 old value");
        elem(32'h0, 2, 0, M_ROW, 1'b1, 0, 8'h00, "R12 new value");

        // R2: back-to-back and gaps
        elem(32'hA1, 0, 0, 32'h0, 1'b0, 0, 8'h00, "R2 b2b first");
        elem(32'hA2, 1, 0, 32'h0, 1'b0, 0, 8'h00, "R2 b2b second");
        idle("R2 gap");
        idle("R2 gap");
        elem(32'hA3, 2, 0, 32'h0, 1'b0, 0, 8'h00, "R2 after gap");
        idle("R2 tail");

        repeat (3) @(posedge clk);
        #2;
        finish_run();
    end

endmodule